// File: doc/BRIEF.md
# Nibble-Coded Accumulator Processor

This block is a very small 8-bit processor built around one accumulator (A), a helper operand register (B), a 4-bit program counter, a 4-bit memory address register, an instruction register and a carry flag. Program and data share one 16-byte store. Each instruction is a single byte: the upper four bits select the operation and the lower four bits carry either a memory address or a 4-bit immediate. The core can load, store, add, subtract, jump unconditionally or on the carry flag, emit a byte on an output register, and stop.

Before a program runs, it is placed in memory through a byte-wide load port. This port is honoured only while the synchronous reset is held high. When reset is released, the core fetches from address 0 and steps through a fixed multicycle sequence for each instruction. It reports each emitted byte with a one-cycle strobe. A level output shows that the core has stopped.

Top module: `nibble_cpu`

## Requirements
- R1: While `rst` is high and after it falls, until the first instruction completes, `halted` and `out_valid` are 0 and `out_data` is 0x00. Execution begins at address 0.
- R2: An instruction byte is split as opcode in bits [7:4] and operand in bits [3:0]. Opcode 0001 loads A from memory at the operand address. Opcode 0111 loads A with the operand zero-extended to 8 bits.
- R3: Opcode 0010 first copies the addressed byte into B. It then sets A to (A + B) mod 256 and sets carry to bit 8 of the 9-bit sum.
- R4: Opcode 0011 first copies the addressed byte into B. It then sets A to (A − B) mod 256, computed as A + ~B + 1. Carry is set exactly when A ≥ B, meaning no borrow occurred.
- R5: Only opcodes 0010 and 0011 change the carry flag. Every other instruction leaves it as it was.
- R6: Opcode 0100 writes A into memory at the operand address. Because the store is shared, such a write can replace an instruction that is fetched later.
- R7: Opcode 0110 always loads the PC with the operand. Opcode 1000 does so only when carry is 1. Opcode 1001 does so only when carry is 0. A jump that is not taken leaves the PC at the next address.
- R8: Opcode 1110, whatever its operand, copies A to `out_data` and raises `out_valid` for exactly one cycle. At all other times `out_data` holds its value.
- R9: The byte 0xF0 stops the core. `halted` then stays 1, and PC, A and carry stay unchanged, with no further `out_valid`, until reset.
- R10: The PC advances by one on every fetch and wraps from 15 to 0.
- R11: Every instruction occupies 3 clock cycles, except opcodes 0010 and 0011, which occupy 4. The effect of an output or halt instruction is visible after the third rising edge of that instruction.
- R12: The load port writes `ld_data` to address `ld_addr` on a rising edge only when both `rst` and `ld_en` are high. While the core runs, `ld_en` has no effect.
- R13: These bytes change nothing except the PC, which still advances: opcode 0000 with any operand, opcodes 0101 and 1010 to 1101, and opcode 1111 with a nonzero operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; enables the load port |
| ld_en | input | 1 | Load-port write enable, honoured only during reset |
| ld_addr | input | 4 | Load-port byte address |
| ld_data | input | 8 | Load-port byte value |
| out_data | output | 8 | Last byte emitted by the output instruction |
| out_valid | output | 1 | One-cycle strobe marking a new `out_data` |
| halted | output | 1 | High once the stop byte has executed |

## Verification
The bench targets several corner cases where a faulty design leaves a visible mark. One is the carry edge: a sum that overflows 8 bits, a difference that borrows, and a difference of equal values. A design that inverted the subtraction carry would take the wrong branch on the following conditional jump. Another is carry retention across stores, loads and no-ops. A design that cleared or recomputed carry on those instructions would skip a branch the bench expects to be taken.

Further cases are a program that overwrites one of its own later instructions, and a program that runs off address 15 and reaches a stop byte at address 0 only by wrapping. A design that prefetched instructions or failed to wrap would emit extra bytes or never stop. Random programs then run while the load port is driven with noise. Each output strobe, output value and halt cycle is compared against a cycle-counted model, so a wrong instruction length or a leaky load port shows up as a shifted or corrupted trace.

// File: rtl/nibble_cpu_pkg.sv
package nibble_cpu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LDA = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'h2;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'h3;
  localparam logic [OPC_W-1:0] OPC_STA = 4'h4;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'h6;
  localparam logic [OPC_W-1:0] OPC_LDI = 4'h7;
  localparam logic [OPC_W-1:0] OPC_JC  = 4'h8;
  localparam logic [OPC_W-1:0] OPC_JNC = 4'h9;
  localparam logic [OPC_W-1:0] OPC_OUT = 4'hE;
  localparam logic [OPC_W-1:0] OPC_HLT = 4'hF;

  typedef enum logic [2:0] {
    PH_ADDR  = 3'd0,
    PH_FETCH = 3'd1,
    PH_EXEC  = 3'd2,
    PH_ALU   = 3'd3,
    PH_HALT  = 3'd4
  } phase_e;

  function automatic logic uses_alu(input logic [OPC_W-1:0] op);
    return (op == OPC_ADD) || (op == OPC_SUB);
  endfunction

  function automatic logic jump_taken(input logic [OPC_W-1:0] op, input logic cy);
    return (op == OPC_JMP) || ((op == OPC_JC) && cy) || ((op == OPC_JNC) && !cy);
  endfunction

endpackage

// File: rtl/nibble_cpu_ram.sv
module nibble_cpu_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] words;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(i))) word_q <= wdata;
    end
    assign words[i] = word_q;
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/nibble_cpu_alu.sv
module nibble_cpu_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] result,
  output logic          carry_out
);
  function automatic logic [DW:0] addsub(input logic [DW-1:0] x,
                                         input logic [DW-1:0] y,
                                         input logic          minus);
    logic [DW-1:0] y_eff;
    y_eff = minus ? ~y : y;
    return {1'b0, x} + {1'b0, y_eff} + (DW+1)'(minus);
  endfunction

  logic [DW:0] wide;

  always_comb begin
    wide      = addsub(a, b, sub);
    result    = wide[DW-1:0];
    carry_out = wide[DW];
  end

endmodule

// File: rtl/nibble_cpu_seq.sv
module nibble_cpu_seq
  import nibble_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             opd_zero,
  input  logic             carry,
  output logic             ev_mar_pc,
  output logic             ev_fetch,
  output logic             ev_ld_a_mem,
  output logic             ev_ld_b,
  output logic             ev_store,
  output logic             ev_ld_imm,
  output logic             ev_jump,
  output logic             ev_out,
  output logic             ev_alu_wb,
  output logic             ev_sub,
  output logic             halted
);
  phase_e phase_q, phase_d;
  logic   in_exec;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_ADDR:  phase_d = PH_FETCH;
      PH_FETCH: phase_d = PH_EXEC;
      PH_EXEC: begin
        if (uses_alu(opcode))                  phase_d = PH_ALU;
        else if (opcode == OPC_HLT && opd_zero) phase_d = PH_HALT;
        else                                    phase_d = PH_ADDR;
      end
      PH_ALU:   phase_d = PH_ADDR;
      PH_HALT:  phase_d = PH_HALT;
      default:  phase_d = PH_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_ADDR;
    else     phase_q <= phase_d;
  end

  assign in_exec     = (phase_q == PH_EXEC);
  assign ev_mar_pc   = (phase_q == PH_ADDR);
  assign ev_fetch    = (phase_q == PH_FETCH);
  assign ev_ld_a_mem = in_exec && (opcode == OPC_LDA);
  assign ev_ld_b     = in_exec && uses_alu(opcode);
  assign ev_store    = in_exec && (opcode == OPC_STA);
  assign ev_ld_imm   = in_exec && (opcode == OPC_LDI);
  assign ev_jump     = in_exec && jump_taken(opcode, carry);
  assign ev_out      = in_exec && (opcode == OPC_OUT);
  assign ev_alu_wb   = (phase_q == PH_ALU);
  assign ev_sub      = (opcode == OPC_SUB);
  assign halted      = (phase_q == PH_HALT);

endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
  import nibble_cpu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          halted
);
  localparam int EXT_W = DW - AW;

  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] ir_q, a_q, b_q;
  logic          carry_q;

  logic [DW-1:0] rd_data;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  logic [DW-1:0] alu_res;
  logic          alu_cy;

  logic [OPC_W-1:0] opcode;
  logic [AW-1:0]    operand;

  logic ev_mar_pc, ev_fetch, ev_ld_a_mem, ev_ld_b, ev_store;
  logic ev_ld_imm, ev_jump, ev_out, ev_alu_wb, ev_sub;

  assign opcode  = ir_q[DW-1 -: OPC_W];
  assign operand = ir_q[AW-1:0];

  nibble_cpu_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .opcode      (opcode),
    .opd_zero    (operand == '0),
    .carry       (carry_q),
    .ev_mar_pc   (ev_mar_pc),
    .ev_fetch    (ev_fetch),
    .ev_ld_a_mem (ev_ld_a_mem),
    .ev_ld_b     (ev_ld_b),
    .ev_store    (ev_store),
    .ev_ld_imm   (ev_ld_imm),
    .ev_jump     (ev_jump),
    .ev_out      (ev_out),
    .ev_alu_wb   (ev_alu_wb),
    .ev_sub      (ev_sub),
    .halted      (halted)
  );

  assign mem_we    = rst ? ld_en   : ev_store;
  assign mem_waddr = rst ? ld_addr : mar_q;
  assign mem_wdata = rst ? ld_data : a_q;

  nibble_cpu_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar_q),
    .rdata (rd_data)
  );

  nibble_cpu_alu #(.DW(DW)) u_alu (
    .a         (a_q),
    .b         (b_q),
    .sub       (ev_sub),
    .result    (alu_res),
    .carry_out (alu_cy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
    end else begin
      if (ev_mar_pc) mar_q <= pc_q;
      if (ev_fetch) begin
        ir_q  <= rd_data;
        mar_q <= rd_data[AW-1:0];
        pc_q  <= pc_q + AW'(1);
      end
      if (ev_jump) pc_q <= operand;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      carry_q <= 1'b0;
    end else begin
      if (ev_ld_a_mem) a_q <= rd_data;
      if (ev_ld_imm)   a_q <= {{EXT_W{1'b0}}, operand};
      if (ev_ld_b)     b_q <= rd_data;
      if (ev_alu_wb) begin
        a_q     <= alu_res;
        carry_q <= alu_cy;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= ev_out;
      if (ev_out) out_data <= a_q;
    end
  end

endmodule

// File: rtl/nibble_cpu_checker.sv
module nibble_cpu_checker #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] out_data,
  input logic          out_valid,
  input logic          halted,
  input logic [AW-1:0] pc_q,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] ir_q,
  input logic          carry_q,
  input logic          ev_fetch,
  input logic          ev_jump,
  input logic          ev_alu_wb
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid |=> !out_valid);

  a_r8_data_holds: assert property (@(posedge clk) disable iff (rst || !armed)
    (out_data != $past(out_data)) |-> out_valid);

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst || !armed)
    halted |=> halted);

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst || !armed)
    halted |=> ($stable(pc_q) && $stable(a_q) && $stable(carry_q)));

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst || !armed)
    halted |-> !out_valid);

  a_r5_carry_kept: assert property (@(posedge clk) disable iff (rst || !armed)
    !ev_alu_wb |=> $stable(carry_q));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_jump |=> (pc_q == $past(ir_q[AW-1:0])));

  a_r10_pc_step: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_fetch |=> (pc_q == ($past(pc_q) + AW'(1))));

  a_r11_fetch_gap: assert property (@(posedge clk) disable iff (rst || !armed)
    ev_fetch |=> !ev_fetch);

endmodule

bind nibble_cpu nibble_cpu_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_data  (out_data),
  .out_valid (out_valid),
  .halted    (halted),
  .pc_q      (pc_q),
  .a_q       (a_q),
  .ir_q      (ir_q),
  .carry_q   (carry_q),
  .ev_fetch  (ev_fetch),
  .ev_jump   (ev_jump),
  .ev_alu_wb (ev_alu_wb)
);

// File: tb/nibble_cpu_test.sv
`timescale 1ns/1ps
module nibble_cpu_test;
  localparam int W = 120;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  wire  [7:0] out_data;
  wire        out_valid;
  wire        halted;

  always #10 clk = ~clk;

  nibble_cpu uut (
    .clk (clk), .rst (rst), .ld_en (ld_en), .ld_addr (ld_addr),
    .ld_data (ld_data), .out_data (out_data), .out_valid (out_valid),
    .halted (halted)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] prog [16];
  bit         exp_v [W+1];
  bit         exp_h [W+1];
  int         exp_d [W+1];
  int         got_out [W+1];
  int         got_n;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sum9(input int x, input int y);
    return x + y;
  endfunction

  function automatic bit no_borrow(input int x, input int y);
    return x >= y;
  endfunction

  task automatic model();
    int m [16];
    int ev [W+1];
    int a = 0, b = 0, pc = 0, c = 0, cyc = 0, len, ins, op, opd, curd;
    bit hlt = 0;
    for (int i = 0; i < 16; i++) m[i] = prog[i];
    for (int k = 0; k <= W; k++) begin
      exp_v[k] = 0; exp_h[k] = 0; ev[k] = 0;
    end
    while (!hlt && cyc < W) begin
      ins = m[pc]; op = ins / 16; opd = ins % 16;
      pc = (pc + 1) % 16; len = 3;
      case (op)
        1:  a = m[opd];
        2:  begin b = m[opd]; c = (sum9(a, b) > 255); a = sum9(a, b) % 256; len = 4; end
        3:  begin b = m[opd]; c = no_borrow(a, b); a = (a - b + 256) % 256; len = 4; end
        4:  m[opd] = a;
        6:  pc = opd;
        7:  a = opd;
        8:  if (c == 1) pc = opd;
        9:  if (c == 0) pc = opd;
        14: if (cyc + 3 <= W) begin exp_v[cyc+3] = 1; ev[cyc+3] = a; end
        15: if (opd == 0) begin
              hlt = 1;
              for (int k = cyc + 3; k <= W; k++) exp_h[k] = 1;
            end
        default: ;
      endcase
      cyc += len;
    end
    curd = 0;
    for (int k = 0; k <= W; k++) begin
      if (exp_v[k]) curd = ev[k];
      exp_d[k] = curd;
    end
  endtask

  // noise: 0 = port idle, 1 = random writes, 2 = constant write of 0xFF to 15
  task automatic run(input string req, input int noise);
    int mism = 0, fk = 0, fa = 0, fe = 0;
    rst = 1'b1; ld_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      ld_en = 1'b1; ld_addr = 4'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    // R1: outputs cleared while held in reset
    check(out_valid === 1'b0 && halted === 1'b0 && out_data === 8'h00, "R1",
          "reset outputs {halted,valid,data}", int'({halted, out_valid, out_data}), 0);
    model();
    rst = 1'b0;
    got_n = 0;
    for (int k = 1; k <= W; k++) begin
      if (noise == 1) begin
        ld_en = 1'($urandom); ld_addr = 4'($urandom); ld_data = 8'($urandom);
      end else if (noise == 2) begin
        ld_en = 1'b1; ld_addr = 4'hF; ld_data = 8'hFF;
      end
      @(negedge clk);
      if (out_valid === 1'b1) begin
        got_out[got_n] = int'(out_data);
        got_n++;
      end
      if (out_valid !== exp_v[k] || int'(out_data) != exp_d[k] || halted !== exp_h[k]) begin
        if (mism == 0) begin
          fk = k;
          fa = int'({halted, out_valid, out_data});
          fe = (int'(exp_h[k]) << 9) | (int'(exp_v[k]) << 8) | exp_d[k];
        end
        mism++;
      end
    end
    ld_en = 1'b0;
    check(mism == 0, req, $sformatf("trace at cycle %0d {halted,valid,data}", fk), fa, fe);
  endtask

  task automatic expect_outs(input string req, input int n, input int v0, input int v1);
    check(got_n == n, req, "output count", got_n, n);
    if (n > 0) check(got_out[0] == v0, req, "first output", got_out[0], v0);
    if (n > 1) check(got_out[1] == v1, req, "second output", got_out[1], v1);
  endtask

  task automatic load(input logic [7:0] p [16]);
    for (int i = 0; i < 16; i++) prog[i] = p[i];
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R11", "watchdog cycles", 200000, 0);
    finish_up();
  end

  initial begin
    logic [7:0] p [16];
    int ops [18] = '{0, 1, 2, 3, 4, 6, 7, 8, 9, 14, 14, 7, 1, 2, 3, 15, 5, 10};
    void'($urandom(32'd20240611));

    // R3 and R7: 200+100 overflows to 44 with carry, JC taken
    p = '{8'h1E, 8'h2F, 8'hE0, 8'h86, 8'h71, 8'hF0, 8'h79, 8'hE0,
          8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC8, 8'h64};
    load(p); run("R3", 0); expect_outs("R3", 2, 44, 9);
    check(halted === 1'b1, "R9", "halted after stop byte", int'(halted), 1);

    // R4: 3-5 borrows: 254, carry clear, JNC taken
    p = '{8'h1E, 8'h3F, 8'hE0, 8'h96, 8'h71, 8'hF0, 8'h75, 8'hE0,
          8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h05};
    load(p); run("R4", 0); expect_outs("R4", 2, 254, 5);

    // R4 and R7: 7-7 gives 0 with carry set, JC taken
    p = '{8'h1E, 8'h3F, 8'hE0, 8'h86, 8'h71, 8'hF0, 8'h75, 8'hE0,
          8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h07, 8'h07};
    load(p); run("R7", 0); expect_outs("R7", 2, 0, 5);

    // R5: carry survives LDI, STA, LDA, OUT, NOP before JC
    p = '{8'h1E, 8'h2F, 8'h73, 8'h4D, 8'h1D, 8'hE0, 8'h00, 8'h8A,
          8'h71, 8'hE0, 8'h7C, 8'hE0, 8'hF0, 8'h00, 8'hC8, 8'h64};
    load(p); run("R5", 0); expect_outs("R5", 2, 3, 12);

    // R6: store then reload; store also turns a later OUT into a no-op
    p = '{8'h79, 8'h4C, 8'h70, 8'h46, 8'h1C, 8'hE0, 8'hE0, 8'hF0,
          8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    load(p); run("R6", 0); expect_outs("R6", 1, 9, 0);

    // R10 and R8: stop byte written at address 0 is reached only by wrapping
    p = '{8'hE0, 8'h7F, 8'h2E, 8'h40, 8'h76, 8'h00, 8'h00, 8'h00,
          8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hE1, 8'h00};
    load(p); run("R10", 0); expect_outs("R10", 2, 0, 6);
    check(halted === 1'b1, "R10", "halted after wrap", int'(halted), 1);

    // R13: undefined codes change nothing
    p = '{8'h73, 8'h5A, 8'hA7, 8'hB7, 8'hC1, 8'hD2, 8'hF3, 8'h0C,
          8'hE0, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    load(p); run("R13", 0); expect_outs("R13", 1, 3, 0);

    // R12: load port held active while running has no effect
    p = '{8'h1F, 8'hE0, 8'h1F, 8'hE0, 8'hF0, 8'h00, 8'h00, 8'h00,
          8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A};
    load(p); run("R12", 2); expect_outs("R12", 2, 90, 90);

    // R2: LDI zero-extends over a full accumulator
    p = '{8'h1F, 8'h7A, 8'hE0, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00,
          8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF};
    load(p); run("R2", 0); expect_outs("R2", 1, 10, 0);

    // R11: random programs with load-port noise against the cycle model
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < 16; i++) begin
        int op, opd;
        op  = ops[$urandom % 18];
        opd = $urandom % 16;
        if (op == 15 && ($urandom % 2) == 0) opd = 0;
        prog[i] = 8'((op << 4) | opd);
      end
      run("R11", 1);
    end

    finish_up();
  end

endmodule